// File: doc/BRIEF.md
# Layer Phase Sequencing Controller

This controller walks one inference through the layers of a neural network accelerator that predicts which neurons are active by means of a low-rank factorisation of each weight matrix. A hidden layer needs three passes through the five-stage datapath (address, fetch, multiply, add, activation and write-back). The first pass projects the input onto the small rank space. The second expands that result into a per-neuron predictor. The third is the full weight pass, with the activation function applied. The last layer needs only the full weight pass, and its results go out without the activation function.

Each pass reads what the previous pass wrote. The controller therefore holds the pipeline idle for a fixed three-cycle drain between dependent passes. Throughout that drain it keeps the issue enable low. The datapath reports the end of each pass with a one-cycle finish pulse. The controller answers by driving a phase code, an issue enable, an activation enable and the index of the layer in progress, and it raises a done pulse when the last layer is finished.

Top module: `layer_phase_seq`

## Requirements
- R1: After reset, and after any reset in the middle of a run, phase_o is 0 (idle) and issue_o, nl_en_o, done_o and layer_idx_o are all 0.
- R2: A start_i pulse while idle clears layer_idx_o to 0. If layer_count_i is 2 or more, phase_o becomes 1 (rank projection) on the next cycle. If layer_count_i is 0 or 1, phase_o becomes 4 (output weight pass) on the next cycle.
- R3: A hidden layer moves from phase 1 to phase 2 (predictor expansion) on v_fin_i, and from phase 2 to phase 3 (hidden weight pass) on u_fin_i, with a drain between each pair. Without its finish pulse, a phase holds.
- R4: Every drain shows phase_o = 5 for exactly 3 consecutive cycles, starting the cycle after the finish pulse, and the following phase appears on the fourth cycle.
- R5: issue_o is 1 in phases 1, 2, 3 and 4. It is 0 in phase 0 and phase 5.
- R6: nl_en_o is 1 only in phase 3. It is 0 in phase 4 and in every other phase.
- R7: A w_fin_i pulse in phase 3 increments layer_idx_o on the next cycle and enters a drain. After the drain, phase_o is 4 if the new index is at least layer_count_i − 1 or if last_layer_i was high with the pulse. Otherwise phase_o is 1.
- R8: A w_fin_i pulse in phase 4 produces done_o = 1 for exactly one cycle, on the next cycle, together with phase_o = 0. The layer index is held.
- R9: Finish pulses that do not belong to the current phase have no effect, and this includes pulses during a drain and in idle. A start_i pulse while busy also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an inference (taken only when idle) |
| v_fin_i | input | 1 | Rank projection pass finished |
| u_fin_i | input | 1 | Predictor expansion pass finished |
| w_fin_i | input | 1 | Weight pass finished (hidden or output) |
| last_layer_i | input | 1 | Forces the next layer to be the output layer |
| layer_count_i | input | 3 | Number of weight layers in the network |
| phase_o | output | 3 | 0 idle, 1 projection, 2 expansion, 3 hidden weights, 4 output weights, 5 drain |
| nl_en_o | output | 1 | Apply the activation function at write-back |
| issue_o | output | 1 | Datapath may issue new pipeline work |
| layer_idx_o | output | 3 | Index of the layer in progress |
| done_o | output | 1 | One-cycle pulse when the output layer ends |

## Verification
Four rules are checked on every cycle. No drain runs longer or shorter than three cycles. The issue enable is low throughout a drain. The activation enable is never high outside the hidden weight pass. A hidden weight finish always advances the layer index by one. The same per-cycle checks cover holding a phase until its own finish pulse and raising done only just after the output pass. Only the bench scenarios can show that the complete phase order is right for each combination of layer count and last-layer override, and that stray starts or foreign finish pulses leave a run undisturbed. The same holds for the one-layer shortcut straight to the output pass and for recovery from a reset in the middle of a run.

// File: rtl/layer_phase_pkg.sv
package layer_phase_pkg;

    localparam int LAYER_W = 3;
    localparam int DRAIN_CYC = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROJ,
        ST_GAP_PE,
        ST_EXPAND,
        ST_GAP_EW,
        ST_HWGT,
        ST_GAP_WN,
        ST_OWGT
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PROJ  = 3'd1,
        PH_EXP   = 3'd2,
        PH_HWGT  = 3'd3,
        PH_OWGT  = 3'd4,
        PH_DRAIN = 3'd5
    } phase_code_t;

    typedef struct packed {
        phase_code_t phase;
        logic        issue;
        logic        nl_en;
    } phase_out_t;

    function automatic phase_code_t phase_of(input seq_state_t s);
        case (s)
            ST_PROJ:   phase_of = PH_PROJ;
            ST_EXPAND: phase_of = PH_EXP;
            ST_HWGT:   phase_of = PH_HWGT;
            ST_OWGT:   phase_of = PH_OWGT;
            ST_GAP_PE,
            ST_GAP_EW,
            ST_GAP_WN: phase_of = PH_DRAIN;
            default:   phase_of = PH_IDLE;
        endcase
    endfunction

    function automatic phase_out_t decode_out(input seq_state_t s);
        phase_out_t o;
        o.phase = phase_of(s);
        o.issue = (o.phase != PH_IDLE) && (o.phase != PH_DRAIN);
        o.nl_en = (s == ST_HWGT);
        return o;
    endfunction

endpackage

// File: rtl/layer_phase_drain.sv
module layer_phase_drain #(
    parameter int DRAIN = layer_phase_pkg::DRAIN_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic last_o
);
    localparam int CW = (DRAIN > 1) ? $clog2(DRAIN) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DRAIN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/layer_phase_ctr.sv
module layer_phase_ctr #(
    parameter int LW = layer_phase_pkg::LAYER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          inc_i,
    input  logic [LW-1:0] count_i,
    input  logic          force_last_i,
    output logic [LW-1:0] idx_o,
    output logic          first_is_out_o,
    output logic          next_is_out_o
);
    localparam int EW = LW + 2;

    logic [LW-1:0] idx_q;
    logic [EW-1:0] idx_plus2;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            idx_q <= '0;
        end else if (inc_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // new index (idx+1) >= count-1  <=>  idx+2 >= count
    assign idx_plus2      = EW'(idx_q) + EW'(2);
    assign next_is_out_o  = force_last_i || (idx_plus2 >= EW'(count_i));
    assign first_is_out_o = (count_i <= LW'(1));
    assign idx_o          = idx_q;
endmodule

// File: rtl/layer_phase_fsm.sv
module layer_phase_fsm
    import layer_phase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       v_fin_i,
    input  logic       u_fin_i,
    input  logic       w_fin_i,
    input  logic       gap_last_i,
    input  logic       first_is_out_i,
    input  logic       next_is_out_i,
    output seq_state_t state_o,
    output logic       gap_load_o,
    output logic       ctr_clear_o,
    output logic       ctr_inc_o,
    output logic       done_o
);
    seq_state_t state_q, state_d;
    logic       to_out_q, to_out_d;
    logic       done_q;

    always_comb begin
        state_d     = state_q;
        to_out_d    = to_out_q;
        gap_load_o  = 1'b0;
        ctr_clear_o = 1'b0;
        ctr_inc_o   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    ctr_clear_o = 1'b1;
                    state_d     = first_is_out_i ? ST_OWGT : ST_PROJ;
                end
            end
            ST_PROJ: begin
                if (v_fin_i) begin
                    state_d    = ST_GAP_PE;
                    gap_load_o = 1'b1;
                end
            end
            ST_GAP_PE: if (gap_last_i) state_d = ST_EXPAND;
            ST_EXPAND: begin
                if (u_fin_i) begin
                    state_d    = ST_GAP_EW;
                    gap_load_o = 1'b1;
                end
            end
            ST_GAP_EW: if (gap_last_i) state_d = ST_HWGT;
            ST_HWGT: begin
                if (w_fin_i) begin
                    state_d    = ST_GAP_WN;
                    gap_load_o = 1'b1;
                    ctr_inc_o  = 1'b1;
                    to_out_d   = next_is_out_i;
                end
            end
            ST_GAP_WN: if (gap_last_i) state_d = to_out_q ? ST_OWGT : ST_PROJ;
            ST_OWGT:   if (w_fin_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            to_out_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            to_out_q <= to_out_d;
            done_q   <= (state_q == ST_OWGT) && w_fin_i;
        end
    end

    assign state_o = state_q;
    assign done_o  = done_q;
endmodule

// File: rtl/layer_phase_seq.sv
module layer_phase_seq
    import layer_phase_pkg::*;
#(
    parameter int LW    = LAYER_W,
    parameter int DRAIN = DRAIN_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          v_fin_i,
    input  logic          u_fin_i,
    input  logic          w_fin_i,
    input  logic          last_layer_i,
    input  logic [LW-1:0] layer_count_i,
    output logic [2:0]    phase_o,
    output logic          nl_en_o,
    output logic          issue_o,
    output logic [LW-1:0] layer_idx_o,
    output logic          done_o
);
    seq_state_t state;
    phase_out_t outs;
    logic gap_load, gap_last, ctr_clear, ctr_inc, first_out, next_out;

    layer_phase_drain #(.DRAIN(DRAIN)) u_drain (
        .clk(clk), .rst(rst), .load_i(gap_load), .last_o(gap_last)
    );

    layer_phase_ctr #(.LW(LW)) u_ctr (
        .clk(clk), .rst(rst), .clear_i(ctr_clear), .inc_i(ctr_inc),
        .count_i(layer_count_i), .force_last_i(last_layer_i),
        .idx_o(layer_idx_o), .first_is_out_o(first_out),
        .next_is_out_o(next_out)
    );

    layer_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .start_i(start_i), .v_fin_i(v_fin_i),
        .u_fin_i(u_fin_i), .w_fin_i(w_fin_i), .gap_last_i(gap_last),
        .first_is_out_i(first_out), .next_is_out_i(next_out),
        .state_o(state), .gap_load_o(gap_load), .ctr_clear_o(ctr_clear),
        .ctr_inc_o(ctr_inc), .done_o(done_o)
    );

    assign outs    = decode_out(state);
    assign phase_o = outs.phase;
    assign issue_o = outs.issue;
    assign nl_en_o = outs.nl_en;
endmodule

// File: rtl/layer_phase_seq_chk.sv
module layer_phase_seq_chk #(
    parameter int LW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          v_fin_i,
    input logic          w_fin_i,
    input logic [2:0]    phase_o,
    input logic          nl_en_o,
    input logic          issue_o,
    input logic [LW-1:0] layer_idx_o,
    input logic          done_o
);
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else if (phase_o == 3'd5) run_q <= run_q + 3'd1;
        else run_q <= '0;
    end

    // R4
    drain_not_long_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd5) |-> (run_q < 3'd3));

    // R4
    drain_not_short_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o != 3'd5 && run_q != 3'd0) |-> (run_q == 3'd3));

    // R5
    drain_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd5) |-> !issue_o);

    // R6
    nl_only_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        nl_en_o |-> (phase_o == 3'd3));

    // R7
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd3 && w_fin_i) |=> (layer_idx_o == $past(layer_idx_o) + LW'(1)));

    // R3
    proj_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd1 && !v_fin_i) |=> (phase_o == 3'd1));

    // R8
    done_after_out_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (phase_o == 3'd0 && $past(phase_o) == 3'd4));
endmodule

bind layer_phase_seq layer_phase_seq_chk #(.LW(LW)) u_chk (
    .clk(clk), .rst(rst), .v_fin_i(v_fin_i), .w_fin_i(w_fin_i),
    .phase_o(phase_o), .nl_en_o(nl_en_o), .issue_o(issue_o),
    .layer_idx_o(layer_idx_o), .done_o(done_o)
);

// File: tb/tb_layer_phase_seq.sv
module tb_layer_phase_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, v_fin_i = 0, u_fin_i = 0, w_fin_i = 0, last_layer_i = 0;
    logic [2:0] layer_count_i = 3'd0;
    logic [2:0] phase_o;
    logic nl_en_o, issue_o, done_o;
    logic [2:0] layer_idx_o;

    int checks = 0;
    int errs = 0;

    always #2 clk = ~clk;

    layer_phase_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .v_fin_i(v_fin_i),
        .u_fin_i(u_fin_i), .w_fin_i(w_fin_i), .last_layer_i(last_layer_i),
        .layer_count_i(layer_count_i), .phase_o(phase_o), .nl_en_o(nl_en_o),
        .issue_o(issue_o), .layer_idx_o(layer_idx_o), .done_o(done_o)
    );

    // {layer count, last-layer override, expected hidden layers}
    localparam logic [6:0] VEC_TBL [0:6] = '{
        {3'd3, 1'b0, 3'd2},
        {3'd1, 1'b0, 3'd0},
        {3'd5, 1'b1, 3'd1},
        {3'd2, 1'b0, 3'd1},
        {3'd7, 1'b0, 3'd6},
        {3'd0, 1'b0, 3'd0},
        {3'd4, 1'b0, 3'd3}
    };

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse(input int which);
        case (which)
            0: start_i = 1'b1;
            1: v_fin_i = 1'b1;
            2: u_fin_i = 1'b1;
            default: w_fin_i = 1'b1;
        endcase
        tick();
        start_i = 0; v_fin_i = 0; u_fin_i = 0; w_fin_i = 0;
    endtask

    task automatic drain_chk(input int exp_idx);
        for (int c = 0; c < 3; c++) begin
            chk(phase_o, 5, "R4 drain phase");
            chk(issue_o, 0, "R5 no issue in drain");
            chk(layer_idx_o, exp_idx, "R7 index in drain");
            tick();
        end
    endtask

    task automatic run_net(input int cnt, input logic lst, input int hid);
        layer_count_i = 3'(cnt);
        last_layer_i = lst;
        pulse(0);
        for (int h = 0; h < hid; h++) begin
            chk(phase_o, 1, "R2 projection phase");
            chk(issue_o, 1, "R5 issue in projection");
            chk(nl_en_o, 0, "R6 nl off in projection");
            chk(layer_idx_o, h, "R7 layer index");
            pulse(1);
            drain_chk(h);
            chk(phase_o, 2, "R3 expansion phase");
            pulse(2);
            drain_chk(h);
            chk(phase_o, 3, "R3 hidden weight phase");
            chk(nl_en_o, 1, "R6 nl on in hidden weights");
            chk(issue_o, 1, "R5 issue in hidden weights");
            pulse(3);
            drain_chk(h + 1);
        end
        chk(phase_o, 4, "R7 output weight phase");
        chk(nl_en_o, 0, "R6 nl off in output");
        chk(issue_o, 1, "R5 issue in output");
        chk(layer_idx_o, hid, "R7 output index");
        pulse(3);
        chk(done_o, 1, "R8 done pulse");
        chk(phase_o, 0, "R8 idle after output");
        chk(layer_idx_o, hid, "R8 index held");
        tick();
        chk(done_o, 0, "R8 done one cycle");
        last_layer_i = 0;
    endtask

    initial begin
        #400000;
        errs++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        chk(phase_o, 0, "R1 reset phase");
        chk(issue_o, 0, "R1 reset issue");
        chk(nl_en_o, 0, "R1 reset nl");
        chk(done_o, 0, "R1 reset done");
        chk(layer_idx_o, 0, "R1 reset index");

        for (int k = 0; k < 7; k++) begin
            logic [6:0] v;
            v = VEC_TBL[k];
            run_net(int'(v[6:4]), v[3], int'(v[2:0]));
        end

        // R9 stray finishes in idle
        layer_count_i = 3'd3;
        pulse(1); pulse(3);
        chk(phase_o, 0, "R9 idle ignores finishes");
        chk(issue_o, 0, "R9 idle issue stays low");

        // R9 foreign finishes and restart during projection
        pulse(0);
        chk(phase_o, 1, "R2 start to projection");
        pulse(2); pulse(3);
        chk(phase_o, 1, "R9 projection ignores u/w finish");
        pulse(1);
        chk(phase_o, 5, "R4 drain first cycle");
        pulse(1);
        chk(phase_o, 5, "R9 drain ignores finish");
        pulse(0);
        chk(phase_o, 5, "R9 drain ignores start");
        chk(phase_o == 5 ? 1 : 0, 1, "R4 drain third cycle");
        tick();
        chk(phase_o, 2, "R4 drain exactly three cycles");
        chk(layer_idx_o, 0, "R9 start while busy keeps index");

        // R1 reset mid-run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        chk(phase_o, 0, "R1 mid-run reset phase");
        chk(issue_o, 0, "R1 mid-run reset issue");
        chk(layer_idx_o, 0, "R1 mid-run reset index");

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule